// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block sits after a bank of supply comparators. It turns their combined undervoltage flag into a timed, active-low system reset for a processor. It also runs a watchdog that the processor must service by toggling a three-state input. The analog side supplies three signals: a single undervoltage flag, a flag that says threshold configuration has finished, and a strap that turns the watchdog off. The processor's watchdog pin arrives already encoded as low, high or open.

The reset stays asserted while configuration is pending or any supply is low. It is released only after the supplies have been good for a programmable number of clock cycles. Once the reset is released, the watchdog counts clock cycles, and only a clean low-to-high or high-to-low change on its input restarts the count. If the count expires, the block latches a fault flag low and issues one reset pulse. The fault flag outlives that pulse, so software can tell a watchdog reset from a brownout. If the processor never services the watchdog, the block keeps alternating between a timeout interval and a reset pulse.

Top module: `supply_supervisor`

## Requirements
- R1: While the synchronous power-on reset `rst_n` is low, and at the first sample after it, `rst_out_n` is 0 and `wdo_n` is 1.
- R2: `rst_out_n` is 0 on the clock after any edge at which `cfg_done` is 0 or `uv` is 1.
- R3: `rst_out_n` rises exactly `RST_CYCLES` clock edges after the first edge at which `uv` is 0 and `cfg_done` is 1. A `uv` pulse during that wait restarts the full count.
- R4: `wdi_code` is encoded as 2'b00 = low, 2'b01 = high, and 2'b10 or 2'b11 = open. It passes through two synchronizing flops. The first driven level after power-on reset, or after an open period, is only a reference and is not counted as a kick.
- R5: The watchdog timer runs only while `rst_out_n` is 1 and starts from zero at each release. After `WD_CYCLES` edges without a kick, `wdo_n` and `rst_out_n` fall on the same edge, and `rst_out_n` then stays low for exactly `RST_CYCLES` cycles.
- R6: A change of the synchronized input from low to high or from high to low clears the timer and sets `wdo_n` to 1. A change between open and a driven level clears neither the timer nor the fault flag.
- R7: While the input is open, the timer is held at zero and `wdo_n` keeps its value. When the input is driven again, a full `WD_CYCLES` period starts.
- R8: While `rst_out_n` is 0, activity on `wdi_code` changes neither `rst_out_n` nor `wdo_n`.
- R9: Without a kick, the block alternates `WD_CYCLES` cycles with `rst_out_n` high and `RST_CYCLES` cycles low, and `wdo_n` stays 0 throughout. A kick after the pulse sets `wdo_n` back to 1.
- R10: `uv` at a clock edge sets `wdo_n` to 1 on that edge and clears the timer, even in the middle of a watchdog reset pulse.
- R11: With `wd_disable` at 1, the timer never expires and `rst_out_n` falls only through R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_done | input | 1 | Threshold configuration finished |
| uv | input | 1 | Any monitored supply below threshold |
| wd_disable | input | 1 | Watchdog off strap |
| wdi_code | input | 2 | Watchdog input: 00 low, 01 high, 1x open |
| rst_out_n | output | 1 | Active-low system reset |
| wdo_n | output | 1 | Active-low latched watchdog fault |

## Verification
The properties assume that `uv`, `cfg_done` and `wd_disable` are synchronous to `clk` and are sampled at its rising edge. Only `wdi_code` may be asynchronous, because it passes through its own flops. The bench changes every input at the falling edge and reads the outputs there too. Each input change is therefore seen whole at the next rising edge, and the measured widths count the two synchronizer cycles explicitly.

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int RST_CYCLES = 20,
  parameter int WD_CYCLES  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_done,
  input  logic       uv,
  input  logic       wd_disable,
  input  logic [1:0] wdi_code,
  output logic       rst_out_n,
  output logic       wdo_n
);
  localparam int DW = $clog2(RST_CYCLES + 1);
  localparam int WW = $clog2(WD_CYCLES + 1);
  localparam logic [DW-1:0] D_END = DW'(RST_CYCLES - 1);
  localparam logic [WW-1:0] W_END = WW'(WD_CYCLES - 1);
  localparam logic [1:0] OPEN = 2'b10;

  logic [1:0]    s1, s2;
  logic          ref_ok, ref_lvl;
  logic          in_rst, wdo_q;
  logic [DW-1:0] dcnt;
  logic [WW-1:0] wcnt;

  wire driven = ~s2[1];
  wire kick   = driven & ref_ok & (s2[0] != ref_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= OPEN; s2 <= OPEN;
      ref_ok <= 1'b0; ref_lvl <= 1'b0;
      in_rst <= 1'b1; wdo_q <= 1'b1;
      dcnt <= '0; wcnt <= '0;
    end else begin
      s1 <= wdi_code;
      s2 <= s1;
      ref_ok <= driven;
      if (driven) ref_lvl <= s2[0];
      if (uv || !cfg_done) begin
        in_rst <= 1'b1;
        dcnt   <= '0;
        wcnt   <= '0;
        if (uv) wdo_q <= 1'b1;
      end else if (in_rst) begin
        wcnt <= '0;
        if (dcnt == D_END) begin
          in_rst <= 1'b0;
          dcnt   <= '0;
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end else if (wd_disable || !driven) begin
        wcnt <= '0;
      end else if (kick) begin
        wcnt  <= '0;
        wdo_q <= 1'b1;
      end else if (wcnt == W_END) begin
        wcnt   <= '0;
        wdo_q  <= 1'b0;
        in_rst <= 1'b1;
      end else begin
        wcnt <= wcnt + WW'(1);
      end
    end
  end

  assign rst_out_n = ~in_rst;
  assign wdo_n     = wdo_q;
endmodule

// File: rtl/supply_supervisor_sva.sv
module supply_supervisor_sva #(
  parameter int RST_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_done,
  input logic uv,
  input logic wd_disable,
  input logic rst_out_n,
  input logic wdo_n
);
  int quiet;

  always_ff @(posedge clk) begin
    if (!rst_n || rst_out_n || uv || !cfg_done) quiet <= 0;
    else if (quiet < RST_CYCLES) quiet <= quiet + 1;
  end

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (uv || !cfg_done) |=> !rst_out_n); // R2
  AST_RELEASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (quiet == RST_CYCLES)); // R3
  AST_FAULT_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n) |-> $fell(rst_out_n)); // R5
  AST_RESET_FREEZES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !uv) |=> $stable(wdo_n)); // R8
  AST_UV_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> wdo_n); // R10
  AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_disable && rst_out_n && !uv && cfg_done) |=> rst_out_n); // R11
endmodule

bind supply_supervisor supply_supervisor_sva #(.RST_CYCLES(RST_CYCLES)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .uv(uv),
  .wd_disable(wd_disable), .rst_out_n(rst_out_n), .wdo_n(wdo_n)
);

// File: tb/sim_supply_supervisor.sv
`timescale 1ns/1ps
module sim_supply_supervisor;
  localparam int R = 20;
  localparam int W = 200;
  localparam int LIMIT = 4 * W + 4 * R;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, OP = 2'b10;

  logic clk = 1'b0;
  logic rst_n, cfg_done, uv, wd_disable;
  logic [1:0] wdi_code;
  logic rst_out_n, wdo_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.RST_CYCLES(R), .WD_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .uv(uv),
    .wd_disable(wd_disable), .wdi_code(wdi_code),
    .rst_out_n(rst_out_n), .wdo_n(wdo_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rst(input logic lvl, output int n);
    n = 0;
    while (rst_out_n !== lvl && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_done = 1'b0; uv = 1'b0; wd_disable = 1'b0; wdi_code = OP;
    step(3);
    check(rst_out_n === 1'b0, "R1 rst_out_n in reset", int'(rst_out_n), 0);
    check(wdo_n === 1'b1, "R1 wdo_n in reset", int'(wdo_n), 1);
    rst_n = 1'b1;
    step(1);
    check(rst_out_n === 1'b0 && wdo_n === 1'b1, "R1 after reset", int'({rst_out_n, wdo_n}), 1);
  endtask

  task automatic t_config;
    int n;
    step(30);
    check(rst_out_n === 1'b0, "R2 cfg pending", int'(rst_out_n), 0);
    cfg_done = 1'b1; uv = 1'b1;
    step(10);
    check(rst_out_n === 1'b0, "R2 uv held", int'(rst_out_n), 0);
    uv = 1'b0;
    wait_rst(1'b1, n);
    check(n == R, "R3 release delay", n, R);
  endtask

  task automatic t_restart;
    int n;
    uv = 1'b1; step(1); uv = 1'b0;
    step(R / 2);
    check(rst_out_n === 1'b0, "R3 still waiting", int'(rst_out_n), 0);
    uv = 1'b1; step(1); uv = 1'b0;
    wait_rst(1'b1, n);
    check(n == R, "R3 restarted delay", n, R);
  endtask

  task automatic t_open;
    step(3 * W);
    check(rst_out_n === 1'b1 && wdo_n === 1'b1, "R7 open holds timer", int'({rst_out_n, wdo_n}), 3);
  endtask

  task automatic t_timeout;
    int n;
    wdi_code = LO;
    wait_rst(1'b0, n);
    check(n == W + 2, "R4 R5 first timeout", n, W + 2);
    check(wdo_n === 1'b0, "R5 fault latched", int'(wdo_n), 0);
    wait_rst(1'b1, n);
    check(n == R, "R5 pulse width", n, R);
  endtask

  task automatic t_repeat_ignore;
    int n;
    wait_rst(1'b0, n);
    check(n == W, "R9 repeat interval", n, W);
    check(wdo_n === 1'b0, "R9 fault held", int'(wdo_n), 0);
    for (int i = 0; i < 6; i++) begin
      wdi_code = (wdi_code == LO) ? HI : LO;
      step(1);
    end
    wait_rst(1'b1, n);
    check(n + 6 == R, "R8 pulse unaffected", n + 6, R);
    step(10);
    check(wdo_n === 1'b0, "R8 toggles in reset ignored", int'(wdo_n), 0);
  endtask

  task automatic t_open_noclear;
    int n;
    wdi_code = OP; step(4);
    wdi_code = HI; step(10);
    check(wdo_n === 1'b0, "R6 open change no clear", int'(wdo_n), 0);
    wait_rst(1'b0, n);
    check(n == W - 8, "R7 full period after open", n, W - 8);
  endtask

  task automatic t_uv_mid;
    int n;
    step(3);
    uv = 1'b1; step(1);
    check(wdo_n === 1'b1, "R10 uv sets flag", int'(wdo_n), 1);
    check(rst_out_n === 1'b0, "R2 uv mid pulse", int'(rst_out_n), 0);
    uv = 1'b0;
    wait_rst(1'b1, n);
    check(n == R, "R3 R10 release after uv", n, R);
  endtask

  task automatic t_kick;
    int n;
    wait_rst(1'b0, n);
    check(n == W, "R5 timeout from release", n, W);
    wait_rst(1'b1, n);
    wdi_code = LO;
    step(5);
    check(wdo_n === 1'b1 && rst_out_n === 1'b1, "R9 kick clears flag", int'({rst_out_n, wdo_n}), 3);
  endtask

  task automatic t_service;
    int lows = 0;
    for (int i = 0; i < 12; i++) begin
      wdi_code = (wdi_code == LO) ? HI : LO;
      for (int k = 0; k < W / 4; k++) begin
        step(1);
        if (rst_out_n !== 1'b1) lows++;
      end
    end
    check(lows == 0, "R6 serviced no reset", lows, 0);
  endtask

  task automatic t_disable;
    int n;
    wd_disable = 1'b1;
    step(3 * W);
    check(rst_out_n === 1'b1, "R11 disabled no timeout", int'(rst_out_n), 1);
    uv = 1'b1; step(1); uv = 1'b0;
    check(wdo_n === 1'b1, "R11 uv flag high", int'(wdo_n), 1);
    wait_rst(1'b1, n);
    step(2 * W);
    check(rst_out_n === 1'b1 && wdo_n === 1'b1, "R11 still quiet", int'({rst_out_n, wdo_n}), 3);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_config();
    t_restart();
    t_open();
    t_timeout();
    t_repeat_ignore();
    t_open_noclear();
    t_uv_mid();
    t_kick();
    t_service();
    t_disable();
    finish_run();
  end
endmodule